// File: doc/BRIEF.md
# Token-Passing Ring Node

This block is one station on a unidirectional on-chip ring in which the right to start a transaction on a shared medium is never granted by a central arbiter. Instead, a single reserved word, the token, travels from station to station. A station whose attached core is requesting takes the token off the ring and keeps it. While it holds the token its core may use the shared medium. When the core signals completion, the station puts the token back on the ring toward its downstream neighbour. Every other word that arrives is an ordinary data word and is passed on unchanged.

Each ring hop is a valid/ready stream. A word moves across a hop only in a cycle where both valid and ready are high. The station holds a one-word output register. It raises ring-in ready only when that register is empty or is being drained in the same cycle, and only when it is not releasing the token in that cycle. A word held on the ring output while ready is low stays valid and unchanged. The core side is plain level signalling: a request, a done strobe and an ownership flag. Exactly one station per ring is built with the seed option. After reset that station presents the token on its ring output. All other stations start empty.

Top module: `tok_ring_node`

## Requirements
- R1: An incoming word is the token exactly when its top TAG_W bits equal TOKEN_TAG (defaults: 16-bit words, 4-bit tag, tag value 4'hF). Any other tag value, including 4'hE, marks a data word.
- R2: A data word accepted on the ring input appears on the ring output, unchanged and valid, in the next cycle.
- R3: A token accepted while core_req is low is forwarded, unchanged, on the ring output in the next cycle, and core_owns stays low.
- R4: A token accepted while core_req is high is not forwarded. core_owns is high from the next cycle.
- R5: core_owns stays high until core_done is seen high. core_done while core_owns is low has no effect on core_owns or the ring output.
- R6: When core_done is high while core_owns is high and the output register can take a word, core_owns is low in the next cycle. In that same cycle the captured token word is valid on the ring output. During the release cycle ring_in_ready is low.
- R7: After reset core_owns is low. The ring output is valid with the word {TOKEN_TAG, zeros} on the seeded station and not valid on every other station.
- R8: While ring_out_valid is high and ring_out_ready is low, the output word stays valid and stable, and ring_in_ready is low.
- R9: In a ring of stations with one seeded station there is always exactly one token, counting held tokens and tokens valid on ring outputs. A station that starts requesting gets core_owns before the token has been granted to more than N-1 other stations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_in_valid | input | 1 | Upstream hop presents a word |
| ring_in_ready | output | 1 | Station accepts the presented word this cycle |
| ring_in_word | input | W | Word from the upstream station |
| ring_out_valid | output | 1 | Output register holds a word for the downstream hop |
| ring_out_ready | input | 1 | Downstream station accepts the output word |
| ring_out_word | output | W | Word toward the downstream station |
| core_req | input | 1 | Attached core wants the shared medium |
| core_done | input | 1 | Attached core has finished its transaction; held until core_owns falls |
| core_owns | output | 1 | Station holds the token; the core may use the medium |

## Verification
A corrupted ownership state shows at core_owns on the next clock. Within one hop it also shows as either a missing token or a second one somewhere on the ring. The bench therefore counts tokens across all four stations on every cycle. A mistake in the output register or in the tag decode shows as a wrong or missing word on ring_out_word one cycle after acceptance. The bench compares every station's outputs against a behavioural ring model on every clock. It also counts, for each waiting requester, how many other grants happen before its own, so that a starved or skipped station is reported at the moment it is finally served.

// File: rtl/tok_ring_pkg.sv
package tok_ring_pkg;

  typedef enum logic {
    OWN_NONE = 1'b0,
    OWN_HELD = 1'b1
  } own_state_e;

  localparam int unsigned RING_WORD_W = 16;
  localparam int unsigned RING_TAG_W  = 4;

endpackage

// File: rtl/tok_classify.sv
module tok_classify #(
  parameter int unsigned             TAG_W     = 4,
  parameter logic [TAG_W-1:0]        TOKEN_TAG = '1
) (
  input  logic [TAG_W-1:0] tag_bits,
  output logic             is_token
);
  assign is_token = (tag_bits == TOKEN_TAG);
endmodule

// File: rtl/tok_hold_ctl.sv
module tok_hold_ctl
  import tok_ring_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] capture_word,
  input  logic         done,
  input  logic         slot_free,
  output logic         owns,
  output logic         release_now,
  output logic [W-1:0] held_word
);
  own_state_e state_q;

  assign owns        = (state_q == OWN_HELD);
  assign release_now = owns && done && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= OWN_NONE;
      held_word <= '0;
    end else begin
      if (capture) begin
        state_q   <= OWN_HELD;
        held_word <= capture_word;
      end else if (release_now) begin
        state_q <= OWN_NONE;
      end
    end
  end
endmodule

// File: rtl/tok_out_slot.sv
module tok_out_slot #(
  parameter int unsigned W      = 16,
  parameter bit          INIT_V = 1'b0,
  parameter logic [W-1:0] INIT_W = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic         free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= INIT_V;
      out_word  <= INIT_W;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= load_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tok_ring_node.sv
module tok_ring_node
  import tok_ring_pkg::*;
#(
  parameter int unsigned      W          = RING_WORD_W,
  parameter int unsigned      TAG_W      = RING_TAG_W,
  parameter logic [TAG_W-1:0] TOKEN_TAG  = '1,
  parameter bit               SEED_TOKEN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ring_in_valid,
  output logic         ring_in_ready,
  input  logic [W-1:0] ring_in_word,
  output logic         ring_out_valid,
  input  logic         ring_out_ready,
  output logic [W-1:0] ring_out_word,
  input  logic         core_req,
  input  logic         core_done,
  output logic         core_owns
);
  localparam int unsigned  PAY_W     = W - TAG_W;
  localparam logic [W-1:0] SEED_WORD = {TOKEN_TAG, {PAY_W{1'b0}}};

  logic         in_is_tok;
  logic         slot_free;
  logic         release_now;
  logic         accept;
  logic         capture;
  logic         pass;
  logic         load;
  logic [W-1:0] load_word;
  logic [W-1:0] held_word;

  tok_classify #(
    .TAG_W     (TAG_W),
    .TOKEN_TAG (TOKEN_TAG)
  ) u_cls (
    .tag_bits (ring_in_word[W-1 -: TAG_W]),
    .is_token (in_is_tok)
  );

  assign ring_in_ready = slot_free && !release_now;
  assign accept        = ring_in_valid && ring_in_ready;
  assign capture       = accept && in_is_tok && core_req;
  assign pass          = accept && !capture;
  assign load          = release_now || pass;
  assign load_word     = release_now ? held_word : ring_in_word;

  tok_hold_ctl #(
    .W (W)
  ) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (capture),
    .capture_word (ring_in_word),
    .done         (core_done),
    .slot_free    (slot_free),
    .owns         (core_owns),
    .release_now  (release_now),
    .held_word    (held_word)
  );

  generate
    if (SEED_TOKEN) begin : g_seed
      tok_out_slot #(
        .W      (W),
        .INIT_V (1'b1),
        .INIT_W (SEED_WORD)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .out_ready (ring_out_ready),
        .out_valid (ring_out_valid),
        .out_word  (ring_out_word),
        .free      (slot_free)
      );
    end else begin : g_plain
      tok_out_slot #(
        .W      (W),
        .INIT_V (1'b0),
        .INIT_W ('0)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .out_ready (ring_out_ready),
        .out_valid (ring_out_valid),
        .out_word  (ring_out_word),
        .free      (slot_free)
      );
    end
  endgenerate
endmodule

// File: rtl/tok_ring_node_chk.sv
module tok_ring_node_chk #(
  parameter int unsigned      W         = 16,
  parameter int unsigned      TAG_W     = 4,
  parameter logic [TAG_W-1:0] TOKEN_TAG = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ring_in_valid,
  input logic         ring_in_ready,
  input logic [W-1:0] ring_in_word,
  input logic         ring_out_valid,
  input logic         ring_out_ready,
  input logic [W-1:0] ring_out_word,
  input logic         core_req,
  input logic         core_done,
  input logic         core_owns
);
  logic in_acc, in_tok, out_tok;
  assign in_acc  = ring_in_valid && ring_in_ready;
  assign in_tok  = ring_in_word[W-1 -: TAG_W] == TOKEN_TAG;
  assign out_tok = ring_out_word[W-1 -: TAG_W] == TOKEN_TAG;

  p_data_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc && !in_tok |=> ring_out_valid && ring_out_word == $past(ring_in_word));

  p_tok_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc && in_tok && !core_req |=> ring_out_valid && ring_out_word == $past(ring_in_word) && !core_owns);

  p_tok_grab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc && in_tok && core_req |=> core_owns);

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_owns && !core_done |=> core_owns);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_owns && !(in_acc && in_tok && core_req) |=> !core_owns);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_owns && core_done && (!ring_out_valid || ring_out_ready)
      |=> !core_owns && ring_out_valid && out_tok);

  p_release_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_owns && core_done && (!ring_out_valid || ring_out_ready) |-> !ring_in_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_valid && !ring_out_ready |=> ring_out_valid && $stable(ring_out_word));

  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_valid && !ring_out_ready |-> !ring_in_ready);
endmodule

bind tok_ring_node tok_ring_node_chk #(
  .W         (W),
  .TAG_W     (TAG_W),
  .TOKEN_TAG (TOKEN_TAG)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ring_in_valid  (ring_in_valid),
  .ring_in_ready  (ring_in_ready),
  .ring_in_word   (ring_in_word),
  .ring_out_valid (ring_out_valid),
  .ring_out_ready (ring_out_ready),
  .ring_out_word  (ring_out_word),
  .core_req       (core_req),
  .core_done      (core_done),
  .core_owns      (core_owns)
);

// File: tb/tok_ring_node_tb.sv
module tok_ring_node_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          N     = 4;
  localparam int          W     = 16;
  localparam int          TAG_W = 4;
  localparam logic [3:0]  TAG   = 4'hF;
  localparam logic [W-1:0] SEED = {TAG, 12'h000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0] req = '0, done = '0, xdone = '0;
  logic stall = 1'b0, inj = 1'b0;
  logic [W-1:0] inj_word = '0;

  logic [N-1:0] iv, ir, ov, ordy, own;
  logic [N-1:0][W-1:0] iw, ow;

  assign iv[0]     = !stall && (inj || ov[N-1]);
  assign iw[0]     = inj ? inj_word : ow[N-1];
  assign ordy[N-1] = !stall && !inj;

  for (genvar k = 0; k < N; k++) begin : g_node
    if (k > 0) begin : g_link
      assign iv[k]     = ov[k-1];
      assign iw[k]     = ow[k-1];
      assign ordy[k-1] = ir[k];
    end
    tok_ring_node #(.W(W), .TAG_W(TAG_W), .TOKEN_TAG(TAG), .SEED_TOKEN(k == 0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ring_in_valid(iv[k]), .ring_in_ready(ir[k]), .ring_in_word(iw[k]),
      .ring_out_valid(ov[k]), .ring_out_ready(ordy[k]), .ring_out_word(ow[k]),
      .core_req(req[k]), .core_done(done[k]), .core_owns(own[k]));
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  bit           m_ov[N], m_hold[N];
  logic [W-1:0] m_od[N], m_tw[N];
  int hold_len[N], hold_cnt[N], wait_g[N];
  bit waiting[N];

  function automatic bit is_tok(input logic [W-1:0] w);
    return w[W-1 -: TAG_W] == TAG;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    bit rdo[N], lf[N], rel[N], rin[N];
    bit n_ov[N], n_hold[N];
    logic [W-1:0] n_od[N], n_tw[N];
    int tokens;
    // compare the ring against the model
    tokens = 0;
    for (int k = 0; k < N; k++) begin
      chk(own[k] == m_hold[k], m_hold[k] ? "R4" : "R6", W'(own[k]), W'(m_hold[k]));
      chk(ov[k] == m_ov[k], "R2", W'(ov[k]), W'(m_ov[k]));
      if (m_ov[k]) chk(ow[k] == m_od[k], is_tok(m_od[k]) ? "R3" : "R2", ow[k], m_od[k]);
      tokens += int'(own[k]) + int'(ov[k] && is_tok(ow[k]));
    end
    chk(tokens == 1, "R9", W'(tokens), W'(1));
    // attached cores
    for (int k = 0; k < N; k++) begin
      if (m_hold[k]) begin
        hold_cnt[k]++;
        if (hold_cnt[k] == 1) begin
          if (waiting[k]) begin
            chk(wait_g[k] <= N-1, "R9", W'(wait_g[k]), W'(N-1));
            waiting[k] = 0;
          end
          for (int j = 0; j < N; j++) if (j != k && waiting[j]) wait_g[j]++;
        end
        if (hold_cnt[k] >= hold_len[k]) begin
          done[k] = 1'b1;
          req[k]  = 1'b0;
        end else done[k] = 1'b0;
      end else begin
        hold_cnt[k] = 0;
        done[k] = xdone[k];
      end
    end
    // behavioural ring model for the coming edge
    for (int k = N-1; k >= 0; k--) begin
      rdo[k] = (k == N-1) ? (!stall && !inj) : rin[k+1];
      lf[k]  = !m_ov[k] || rdo[k];
      rel[k] = m_hold[k] && done[k] && lf[k];
      rin[k] = lf[k] && !rel[k];
    end
    for (int k = 0; k < N; k++) begin
      bit vin, acc, cap;
      logic [W-1:0] din;
      vin = (k == 0) ? (!stall && (inj || m_ov[N-1])) : m_ov[k-1];
      din = (k == 0) ? (inj ? inj_word : m_od[N-1]) : m_od[k-1];
      acc = vin && rin[k];
      cap = acc && is_tok(din) && req[k];
      n_ov[k] = m_ov[k]; n_od[k] = m_od[k]; n_hold[k] = m_hold[k]; n_tw[k] = m_tw[k];
      if (rel[k]) begin
        n_ov[k] = 1; n_od[k] = m_tw[k]; n_hold[k] = 0;
      end else if (acc && !cap) begin
        n_ov[k] = 1; n_od[k] = din;
      end else if (rdo[k]) n_ov[k] = 0;
      if (cap) begin n_hold[k] = 1; n_tw[k] = din; end
    end
    for (int k = 0; k < N; k++) begin
      m_ov[k] = n_ov[k]; m_od[k] = n_od[k]; m_hold[k] = n_hold[k]; m_tw[k] = n_tw[k];
    end
    @(negedge clk);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    while (m_ov[N-1]) step();
    inj = 1'b1; inj_word = w;
    step();
    inj = 1'b0;
  endtask

  task automatic ask(input int k);
    req[k] = 1'b1; waiting[k] = 1; wait_g[k] = 0;
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      m_ov[k] = (k == 0); m_od[k] = (k == 0) ? SEED : '0;
      m_hold[k] = 0; m_tw[k] = '0; hold_len[k] = 3; hold_cnt[k] = 0; wait_g[k] = 0; waiting[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    chk(ov[0] && ow[0] == SEED, "R7", ow[0], SEED);
    for (int k = 1; k < N; k++) chk(!ov[k], "R7", W'(ov[k]), '0);
    chk(own == '0, "R7", W'(own), '0);

    // R3: free circulation
    repeat (12) step();
    chk(own == '0, "R3", W'(own), '0);

    // R1 R2: data words, including one whose tag is one below the token tag
    send_word(16'h1234);
    chk(ov[0] && ow[0] == 16'h1234, "R2", ow[0], 16'h1234);
    send_word(16'hE123);
    chk(ov[0] && ow[0] == 16'hE123, "R1", ow[0], 16'hE123);
    repeat (8) step();

    // R4 then R6 on station 2
    ask(2);
    for (int i = 0; i < 20 && !m_hold[2]; i++) step();
    chk(own[2], "R4", W'(own[2]), W'(1));
    for (int i = 0; i < 20 && m_hold[2]; i++) step();
    chk(!own[2] && ov[2] && is_tok(ow[2]), "R6", ow[2], SEED);

    // R5: done without holding is ignored
    xdone[1] = 1'b1;
    repeat (6) step();
    chk(!own[1], "R5", W'(own[1]), '0);
    xdone[1] = 1'b0;
    step();

    // R8: back-pressure on the closing hop
    for (int i = 0; i < 20 && !m_ov[N-1]; i++) step();
    begin
      logic [W-1:0] saved;
      saved = ow[N-1];
      stall = 1'b1;
      repeat (3) step();
      chk(ov[N-1] && ow[N-1] == saved, "R8", ow[N-1], saved);
      chk(!ir[N-1], "R8", W'(ir[N-1]), '0);
      stall = 1'b0;
    end

    // R9: every station requests at once, uneven hold lengths
    hold_len[0] = 1; hold_len[1] = 2; hold_len[2] = 4; hold_len[3] = 3;
    for (int k = 0; k < N; k++) ask(k);
    repeat (60) step();
    for (int k = 0; k < N; k++) chk(!waiting[k], "R9", W'(waiting[k]), '0);

    // R9 again with data traffic and a brief stall mixed in
    for (int k = 0; k < N; k++) ask(k);
    send_word(16'h0A5A);
    send_word(16'h7001);
    stall = 1'b1; step(); stall = 1'b0;
    repeat (60) step();
    for (int k = 0; k < N; k++) chk(!waiting[k], "R9", W'(waiting[k]), '0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule